// File: doc/BRIEF.md
# 1-Wire Reset and Presence Sequencer

This block performs the bus master's half of the 1-Wire reset and presence-detect exchange. A one-cycle start strobe, sampled together with a two-bit speed select, launches a sequence. The block first drives an open-drain pull-low enable for the reset pulse. It then releases the line to the weak pullup and samples the bus twice at fixed offsets. The first sample looks for a line that is still low, which means either a short or a slave signalling an interrupt or alarm. The second sample looks for an ordinary presence pulse. When the first sample reads low, a long recheck separates a shorted line from an alarm pulse.

All durations are counted in pulses of a one-microsecond tick input. A tick is one clock wide, and ticks are spaced at least `SYNC_STAGES` clocks apart. The bus input passes through a synchronizer before it is sampled. At the end of the sequence the block returns a two-bit result code with a one-cycle done strobe. A busy output covers the whole sequence, and start requests made while it is high are dropped.

Top module: `owr_rst_seq`

## Requirements
- R1: Speed encoding is 00 standard, 01 overdrive, 10 flexible, and 11 is handled as standard. A start accepted while idle asserts `pull_low` from the next cycle. It stays asserted for exactly 512 ticks at standard or flexible speed, or 64 ticks at overdrive.
- R2: Once `pull_low` has been released within a sequence, it stays deasserted until the sequence ends.
- R3: The first sample is taken 8 ticks (overdrive: 2) after release. If it reads high, the presence sample follows 64 ticks (overdrive: 8) later. A fill delay of 512 ticks (overdrive: 64) then runs. The release period therefore totals 584 or 74 ticks. The result is 00 if the presence sample reads low and 01 if it reads high.
- R4: If the first sample reads low, the bus is sampled again 4096 ticks later. A low recheck ends the sequence with code 11 (short) on that same tick, with no fill delay.
- R5: If the recheck reads high, the fill delay runs and the result is 10 (alarm). No presence test is made: a low bus at the presence offset does not change the code.
- R6: The short and alarm branching of R4 and R5 also applies at overdrive speed, using the overdrive offsets.
- R7: `done` is high for exactly one cycle per sequence. `result` changes only together with `done` and holds its value until the next `done`.
- R8: `busy` is high from the cycle after a start is accepted up to the cycle in which `done` rises, where it falls. A start strobe or speed change while `busy` is high alters neither the timing nor the result.
- R9: While reset is held and right after it, `pull_low`, `busy` and `done` are 0 and `result` is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle timing tick, one per microsecond |
| start | input | 1 | Start strobe, honoured only while idle |
| speed | input | 2 | Speed select captured with start |
| bus_in | input | 1 | Sensed bus level, asynchronous |
| pull_low | output | 1 | Open-drain pull-low enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence strobe |
| result | output | 2 | 00 presence, 01 none, 10 alarm, 11 short |

## Verification
The assertions check the following properties on every cycle:
- `pull_low` stays released once it has been let go.
- `pull_low` is only ever asserted while busy.
- `busy` rises only after a start and falls only with `done`.
- `done` lasts a single cycle.
- `result` moves only with `done`.

The tick counts of each phase can only be shown by the bench's scenarios. The same holds for the choice between presence, none, alarm and short, and for the dropping of starts during a sequence. To do this, the bench counts ticks against a modelled slave whose bus level depends on how far the release period has run.

// File: rtl/owr_pkg.sv
package owr_pkg;

    typedef enum logic [1:0] {
        SPD_STD  = 2'b00,
        SPD_OD   = 2'b01,
        SPD_FLEX = 2'b10,
        SPD_RSVD = 2'b11
    } owr_speed_e;

    typedef enum logic [1:0] {
        RES_PRESENT = 2'b00,
        RES_NONE    = 2'b01,
        RES_ALARM   = 2'b10,
        RES_SHORT   = 2'b11
    } owr_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_SI,
        ST_PDT,
        ST_RECHK,
        ST_FILL
    } owr_state_e;

    function automatic int owr_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/owr_sync.sv
module owr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] stg_d;
            logic [STAGES-1:0] stg_q;

            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                if (i == 0) begin : g_first
                    assign stg_d[i] = d;
                end else begin : g_next
                    assign stg_d[i] = stg_q[i-1];
                end
            end

            // bus idles high through the pullup, so reset to 1
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '1;
                else        stg_q <= stg_d;
            end

            assign q = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/owr_timing.sv
module owr_timing #(
    parameter int W          = 13,
    parameter int T_LOW_STD  = 512,
    parameter int T_LOW_OD   = 64,
    parameter int T_SI_STD   = 8,
    parameter int T_SI_OD    = 2,
    parameter int T_PDT_STD  = 64,
    parameter int T_PDT_OD   = 8,
    parameter int T_FILL_STD = 512,
    parameter int T_FILL_OD  = 64
) (
    input  logic         od,
    output logic [W-1:0] t_low,
    output logic [W-1:0] t_si,
    output logic [W-1:0] t_pdt,
    output logic [W-1:0] t_fill
);
    assign t_low  = od ? W'(T_LOW_OD)  : W'(T_LOW_STD);
    assign t_si   = od ? W'(T_SI_OD)   : W'(T_SI_STD);
    assign t_pdt  = od ? W'(T_PDT_OD)  : W'(T_PDT_STD);
    assign t_fill = od ? W'(T_FILL_OD) : W'(T_FILL_STD);
endmodule

// File: rtl/owr_timer.sv
module owr_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                     cnt_d = load_val;
        else if (tick && cnt_q != '0) cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // the N-th tick after a load of N ends the interval
    assign expire = tick && (cnt_q == W'(1));
endmodule

// File: rtl/owr_rst_seq.sv
module owr_rst_seq
    import owr_pkg::*;
#(
    parameter int T_LOW_STD   = 512,
    parameter int T_LOW_OD    = 64,
    parameter int T_SI_STD    = 8,
    parameter int T_SI_OD     = 2,
    parameter int T_PDT_STD   = 64,
    parameter int T_PDT_OD    = 8,
    parameter int T_FILL_STD  = 512,
    parameter int T_FILL_OD   = 64,
    parameter int T_RECHK     = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       start,
    input  logic [1:0] speed,
    input  logic       bus_in,
    output logic       pull_low,
    output logic       busy,
    output logic       done,
    output logic [1:0] result
);
    localparam int T_MAX = owr_max(owr_max(T_LOW_STD, T_FILL_STD), T_RECHK);
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        owr_state_e  st;
        logic        od;
        owr_result_e pend;
        owr_result_e res;
        logic        done;
    } seq_s;

    seq_s seq_d, seq_q;

    logic             bus_s;
    logic             od_sel;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic [CNT_W-1:0] t_low, t_si, t_pdt, t_fill;

    owr_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (bus_s)
    );

    // speed is taken from the port only while idle, then from the latched copy
    assign od_sel = (seq_q.st == ST_IDLE) ? (speed == SPD_OD) : seq_q.od;

    owr_timing #(
        .W          (CNT_W),
        .T_LOW_STD  (T_LOW_STD),
        .T_LOW_OD   (T_LOW_OD),
        .T_SI_STD   (T_SI_STD),
        .T_SI_OD    (T_SI_OD),
        .T_PDT_STD  (T_PDT_STD),
        .T_PDT_OD   (T_PDT_OD),
        .T_FILL_STD (T_FILL_STD),
        .T_FILL_OD  (T_FILL_OD)
    ) i_timing (
        .od     (od_sel),
        .t_low  (t_low),
        .t_si   (t_si),
        .t_pdt  (t_pdt),
        .t_fill (t_fill)
    );

    owr_timer #(.W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st = ST_LOW;
                    seq_d.od = od_sel;
                    tmr_load = 1'b1;
                    tmr_val  = t_low;
                end
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    seq_d.st = ST_SI;
                    tmr_load = 1'b1;
                    tmr_val  = t_si;
                end
            end
            ST_SI: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (bus_s) begin
                        seq_d.st = ST_PDT;
                        tmr_val  = t_pdt;
                    end else begin
                        seq_d.st = ST_RECHK;
                        tmr_val  = CNT_W'(T_RECHK);
                    end
                end
            end
            ST_PDT: begin
                if (tmr_exp) begin
                    seq_d.st   = ST_FILL;
                    seq_d.pend = bus_s ? RES_NONE : RES_PRESENT;
                    tmr_load   = 1'b1;
                    tmr_val    = t_fill;
                end
            end
            ST_RECHK: begin
                if (tmr_exp) begin
                    if (!bus_s) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.res  = RES_SHORT;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st   = ST_FILL;
                        seq_d.pend = RES_ALARM;
                        tmr_load   = 1'b1;
                        tmr_val    = t_fill;
                    end
                end
            end
            ST_FILL: begin
                if (tmr_exp) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.res  = seq_q.pend;
                    seq_d.done = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.od   <= 1'b0;
            seq_q.pend <= RES_PRESENT;
            seq_q.res  <= RES_PRESENT;
            seq_q.done <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pull_low = (seq_q.st == ST_LOW);
    assign busy     = (seq_q.st != ST_IDLE);
    assign done     = seq_q.done;
    assign result   = seq_q.res;
endmodule

// File: rtl/owr_rst_seq_chk.sv
module owr_rst_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       pull_low,
    input logic       busy,
    input logic       done,
    input logic [1:0] result
);
    a_r1_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> busy);

    a_r1_seq_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> pull_low);

    a_r2_release_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pull_low) |=> !pull_low);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind owr_rst_seq owr_rst_seq_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pull_low (pull_low),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/test_owr_rst_seq.sv
module test_owr_rst_seq;
    localparam int RC = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic       start = 1'b0;
    logic [1:0] speed = 2'b00;
    logic       bus_in = 1'b1;
    logic       pull_low, busy, done;
    logic [1:0] result;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;

    logic [1:0] sc_spd = 2'b00;
    bit  sc_si_low = 0, sc_pd_low = 0, sc_rc_low = 0;

    int  low_ticks = 0, rel_ticks = 0, gap = 1;
    bit  seen_rel = 0, relow = 0;

    owr_rst_seq i_owr_rst_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_us  (tick_us),
        .start    (start),
        .speed    (speed),
        .bus_in   (bus_in),
        .pull_low (pull_low),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    always #4 clk = ~clk;

    function automatic bit is_od(input logic [1:0] s);
        return s == 2'b01;
    endfunction
    function automatic int exp_low(input logic [1:0] s);
        return is_od(s) ? 64 : 512;
    endfunction
    function automatic int exp_si(input logic [1:0] s);
        return is_od(s) ? 2 : 8;
    endfunction
    function automatic int exp_pdt(input logic [1:0] s);
        return is_od(s) ? 8 : 64;
    endfunction
    function automatic int exp_fill(input logic [1:0] s);
        return is_od(s) ? 64 : 512;
    endfunction
    function automatic int exp_code(input bit si_l, input bit pd_l, input bit rc_l);
        if (si_l) return rc_l ? 3 : 2;
        return pd_l ? 0 : 1;
    endfunction
    function automatic int exp_rel(input logic [1:0] s, input bit si_l, input bit rc_l);
        if (!si_l) return exp_si(s) + exp_pdt(s) + exp_fill(s);
        if (rc_l)  return exp_si(s) + RC;
        return exp_si(s) + RC + exp_fill(s);
    endfunction

    // slave model: bus level as a function of ticks seen since release
    function automatic logic bus_model();
        int si, pdt;
        si  = exp_si(sc_spd);
        pdt = exp_pdt(sc_spd);
        if (pull_low) return 1'b0;
        if (rel_ticks <= si) return !sc_si_low;
        if (!sc_si_low) begin
            if (rel_ticks <= si + pdt) return !sc_pd_low;
            return 1'b1;
        end
        if (rel_ticks <= si + pdt) return 1'b0;   // low across the presence offset
        if (rel_ticks <= si + RC) return !sc_rc_low;
        return 1'b1;
    endfunction

    // tick generator, tick counters and bus drive, all on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            tick_us = 1'b0;
            gap = 1;
        end else if (gap == 0) begin
            tick_us = 1'b1;
            gap = $urandom_range(2, 1);
            if (busy) begin
                if (pull_low) low_ticks++;
                else          rel_ticks++;
            end
        end else begin
            tick_us = 1'b0;
            gap--;
        end
        if (busy && !pull_low) seen_rel = 1;
        if (busy && pull_low && seen_rel) relow = 1;
        if (!busy && !done) begin
            low_ticks = 0;
            rel_ticks = 0;
            seen_rel  = 0;
            relow     = 0;
        end
        bus_in = bus_model();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    task automatic run_seq(input logic [1:0] spd, input bit si_l, input bit pd_l,
                           input bit rc_l, input bit poke);
        int w;
        int code;
        sc_spd    = spd;
        sc_si_low = si_l;
        sc_pd_low = pd_l;
        sc_rc_low = rc_l;
        repeat (3) @(negedge clk);
        start = 1'b1;
        speed = spd;
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", int'(busy), 1);
        chk("R1 pull_low after start", int'(pull_low), 1);
        w = 0;
        while (!done && w < 40000) begin
            @(negedge clk);
            w++;
            if (poke && busy && !done && $urandom_range(300, 0) == 0) begin
                start = 1'b1;
                speed = spd ^ 2'b01;
                @(negedge clk);
                w++;
                start = 1'b0;
            end
        end
        code = exp_code(si_l, pd_l, rc_l);
        chk("R7 done seen", int'(done), 1);
        chk("R1 reset pulse ticks", low_ticks, exp_low(spd));
        if (si_l && rc_l)
            chk("R4 short release ticks", rel_ticks, exp_rel(spd, si_l, rc_l));
        else if (si_l)
            chk("R5 alarm release ticks", rel_ticks, exp_rel(spd, si_l, rc_l));
        else
            chk("R3 release ticks", rel_ticks, exp_rel(spd, si_l, rc_l));
        if (si_l && is_od(spd))
            chk("R6 overdrive alarm/short code", int'(result), code);
        else if (si_l && rc_l)
            chk("R4 short code", int'(result), code);
        else if (si_l)
            chk("R5 alarm code", int'(result), code);
        else
            chk("R3 presence code", int'(result), code);
        chk("R2 no pull after release", int'(relow), 0);
        chk("R8 busy low at done", int'(busy), 0);
        if (poke) chk("R8 start while busy ignored", int'(result), code);
        @(negedge clk);
        chk("R7 done one cycle", int'(done), 0);
        speed = 2'b01 ^ spd;
        repeat (4) @(negedge clk);
        chk("R7 result held", int'(result), code);
        chk("R8 idle after sequence", int'(busy), 0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk("R9 reset pull_low", int'(pull_low), 0);
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R9 reset result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 after reset busy", int'(busy), 0);
        chk("R9 after reset result", int'(result), 0);

        // directed corners
        run_seq(2'b00, 0, 1, 0, 0);   // standard, presence
        run_seq(2'b00, 0, 0, 0, 1);   // standard, no presence, pokes
        run_seq(2'b01, 0, 1, 0, 1);   // overdrive, presence
        run_seq(2'b10, 0, 1, 0, 0);   // flexible, presence
        run_seq(2'b11, 0, 0, 0, 0);   // reserved code as standard
        run_seq(2'b01, 1, 0, 1, 1);   // overdrive short
        run_seq(2'b01, 1, 1, 0, 0);   // overdrive alarm
        run_seq(2'b00, 1, 1, 0, 1);   // standard alarm, low at presence offset
        run_seq(2'b10, 1, 0, 1, 0);   // flexible short

        // random mix, recheck kept rare to bound the run
        for (int k = 0; k < 8; k++) begin
            logic [1:0] s;
            bit si_l, pd_l, rc_l;
            s    = 2'($urandom_range(3, 0));
            si_l = ($urandom_range(3, 0) == 0);
            pd_l = 1'($urandom_range(1, 0));
            rc_l = 1'($urandom_range(1, 0));
            run_seq(s, si_l, pd_l, rc_l, 1'($urandom_range(1, 0)));
        end

        summary();
        $finish;
    end
endmodule